// File: doc/BRIEF.md
# I2C Quasi-Bidirectional Port Expander Slave

This block is a bus slave on a two-wire serial bus. It owns one 8-bit quasi-bidirectional port and has no register pointer and no command byte. After a START and a matching address byte, each data byte in a write goes straight into the port latch. Each byte in a read returns a new sample of the port pins. A latch bit written high weakly releases its pin, so that pin can then be used as an input and reads back the level driven from outside.

SCL and SDA are oversampled on the system clock through two-flop synchronizers. START, STOP and the SCL edges are found with edge detectors. The slave pulls SDA low through an open-drain enable output. The 7-bit slave address is a parameter.

Top module: `i2c_port_expander`

## Requirements
- R1: A STOP (SDA rising while SCL is high) at any point returns the block to idle, and SDA is released from then on.
- R2: The first byte after START is compared MSB first: seven address bits, then the R/W bit (1 = read). The slave acknowledges by pulling SDA low in the ninth bit only when the seven bits equal the `SLAVE_ADDR` parameter.
- R3: On an address mismatch the slave never drives SDA and ignores all bytes until the next START. The port latch keeps its value.
- R4: In a write, the slave acknowledges every data byte, and the port latch takes the byte at the start of its acknowledge bit.
- R5: A STOP part-way through a data byte leaves the latch holding the last acknowledged byte.
- R6: In a read, each byte sent MSB first is the value of `port_in`. It is sampled at the SCL falling edge that ends the acknowledge bit just before that byte.
- R7: After the master answers a read byte with no-acknowledge (SDA high), the slave releases SDA until the next START.
- R8: While `rst_n` is low and afterwards, the port latch is all ones, SDA is released and the bus logic is idle.
- R9: A repeated START inside a transfer restarts address reception from bit zero.
- R10: The SDA enable changes only while the synchronized SCL is low. START and STOP handling are the only exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset of the port latch and the bus logic |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| port_in | input | 8 | Sampled pin levels |
| port_out | output | 8 | Port latch; 1 = weak high or input |

## Verification
On every cycle, assertions check three things: STOP and START move the control state as required, SDA is never driven while idle, and the SDA enable moves only while SCL is low. They also check that the latch changes only when a write byte completes. Only the bench scenarios can show the values themselves. Those are the full sweep of written bytes, a read of every pin pattern through the quasi-bidirectional AND with the latch, and the mid-byte STOP, repeated START, wrong-address and reset cases.

// File: rtl/i2c_port_expander.sv
`timescale 1ns/1ps
module i2c_port_expander #(
  parameter logic [6:0] SLAVE_ADDR = 7'h27
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [7:0] port_in,
  output logic [7:0] port_out
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } state_t;

  state_t     st;
  logic [2:0] scl_s, sda_s;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  wire scl       = scl_s[1];
  wire sda       = sda_s[1];
  wire scl_rise  = scl_s[1] & ~scl_s[2];
  wire scl_fall  = ~scl_s[1] & scl_s[2];
  wire start_det = scl & scl_s[2] & sda_s[2] & ~sda;
  wire stop_det  = scl & scl_s[2] & ~sda_s[2] & sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rw       <= 1'b0;
      nack     <= 1'b0;
      port_out <= '1;
    end else if (stop_det) begin
      st <= ST_IDLE;
    end else if (start_det) begin
      st  <= ST_ADDR;
      cnt <= '0;
    end else begin
      case (st)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == ST_WDATA) begin
              port_out <= sh;
              st       <= ST_WACK;
            end else if (sh[7:1] == SLAVE_ADDR) begin
              rw <= sh[0];
              st <= ST_AACK;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            sh <= port_in;
            st <= ST_RDATA;
          end else begin
            st <= ST_WDATA;
          end
        end
        ST_WACK: if (scl_fall) st <= ST_WDATA;
        ST_RDATA: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) st <= ST_RACK;
            else sh <= {sh[6:0], 1'b0};
          end
        end
        ST_RACK: begin
          if (scl_rise) nack <= sda;
          else if (scl_fall) begin
            cnt <= '0;
            if (nack) st <= ST_IDLE;
            else begin
              sh <= port_in;
              st <= ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = (st == ST_AACK) || (st == ST_WACK) || (st == ST_RDATA && !sh[7]);

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe)); // R1
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st == ST_ADDR && cnt == 4'd0)); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe); // R3
  AST_LATCH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_out) |-> $past(st == ST_WDATA)); // R4
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(sda_oe) && !$past(start_det || stop_det)) |-> !scl); // R10

endmodule

// File: tb/i2c_port_expander_tb.sv
`timescale 1ns/1ps
module i2c_port_expander_tb_top;
  localparam logic [6:0] ADDR = 7'h27;
  localparam int P = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] ext = 8'hFF, ext_next = 8'hFF;
  logic sda_oe;
  logic [7:0] port_out, port_in;
  wire sda_line = sda_m & ~sda_oe;
  int vectors = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  assign port_in = port_out & ext;
  always #2 clk = ~clk;

  i2c_port_expander #(.SLAVE_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .port_in(port_in), .port_out(port_out));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected < 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(); repeat (P) @(negedge clk); endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; wt(); scl_m = 1'b1; wt(); r = sda_line; wt(); scl_m = 1'b0; wt();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0; wt();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt();
  endtask

  task automatic xfer(input logic [7:0] o, input logic mack, output logic [7:0] got, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(o[i], r);
      got[i] = r;
    end
    ext = ext_next;
    bus_bit(mack, ack);
  endtask

  initial begin
    logic [7:0] g;
    logic a, r;
    repeat (6) @(negedge clk);
    chk("R8 reset latch", port_out, 8'hFF);
    chk("R8 reset sda", sda_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: wrong address write, no ack, latch untouched
    bus_start();
    xfer({ADDR ^ 7'h01, 1'b0}, 1'b1, g, a);
    chk("R3 nack on mismatch", a, 1);
    xfer(8'h00, 1'b1, g, a);
    chk("R3 data ignored ack", a, 1);
    chk("R3 latch kept", port_out, 8'hFF);
    bus_stop();

    // R3: wrong address read, line released
    bus_start();
    xfer({ADDR ^ 7'h40, 1'b1}, 1'b1, g, a);
    chk("R3 read mismatch nack", a, 1);
    xfer(8'hFF, 1'b1, g, a);
    chk("R3 read mismatch data", g, 8'hFF);
    bus_stop();

    // R2/R4 write sweep over all byte values
    bus_start();
    xfer({ADDR, 1'b0}, 1'b1, g, a);
    chk("R2 address ack", a, 0);
    for (int i = 0; i < 256; i++) begin
      xfer(i[7:0], 1'b1, g, a);
      chk("R4 data ack", a, 0);
      chk("R4 latch value", port_out, i);
    end
    bus_stop();
    chk("R1 released after stop", sda_oe, 0);

    // R6 read sweep with latch all ones, R7 nack at end
    ext_next = 8'h00;
    bus_start();
    xfer({ADDR, 1'b1}, 1'b1, g, a);
    chk("R2 read address ack", a, 0);
    for (int i = 0; i < 256; i++) begin
      ext_next = 8'(i + 1);
      xfer(8'hFF, (i == 255), g, a);
      chk("R6 read value", g, i);
    end
    for (int k = 0; k < 4; k++) begin
      bus_bit(1'b1, r);
      chk("R7 released after nack", r, 1);
    end
    bus_stop();

    // R6 quasi-bidirectional: latch low bits force low reads
    bus_start();
    xfer({ADDR, 1'b0}, 1'b1, g, a);
    xfer(8'hF0, 1'b1, g, a);
    bus_stop();
    ext_next = 8'hAA;
    bus_start();
    xfer({ADDR, 1'b1}, 1'b1, g, a);
    ext_next = 8'h3C;
    xfer(8'hFF, 1'b0, g, a);
    chk("R6 latch and pins", g, 8'hA0);
    xfer(8'hFF, 1'b1, g, a);
    chk("R6 resampled byte", g, 8'h30);
    bus_stop();
    ext = 8'hFF; ext_next = 8'hFF;

    // R5: STOP mid-byte keeps last acked byte
    bus_start();
    xfer({ADDR, 1'b0}, 1'b1, g, a);
    xfer(8'h5A, 1'b1, g, a);
    for (int k = 0; k < 4; k++) bus_bit(1'b0, r);
    bus_stop();
    chk("R5 latch after mid stop", port_out, 8'h5A);
    chk("R1 sda after mid stop", sda_oe, 0);

    // R9: repeated START mid-byte restarts address reception
    bus_start();
    xfer({ADDR, 1'b0}, 1'b1, g, a);
    for (int k = 0; k < 3; k++) bus_bit(1'b0, r);
    bus_start();
    xfer({ADDR, 1'b0}, 1'b1, g, a);
    chk("R9 address ack after restart", a, 0);
    xfer(8'h3C, 1'b1, g, a);
    chk("R9 latch after restart", port_out, 8'h3C);
    bus_stop();

    // R8: reset mid transfer
    bus_start();
    xfer({ADDR, 1'b0}, 1'b1, g, a);
    xfer(8'h00, 1'b1, g, a);
    chk("R4 latch zero", port_out, 8'h00);
    bus_bit(1'b1, r);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 latch after reset", port_out, 8'hFF);
    chk("R8 sda after reset", sda_oe, 0);
    sda_m = 1'b1; scl_m = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_start();
    xfer({ADDR, 1'b0}, 1'b1, g, a);
    chk("R8 address ack after reset", a, 0);
    bus_stop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule